// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters behind one 32-bit register window. Software reaches it through a simple bus with single-cycle read and write strobes. Read data is combinational and is valid in the same cycle as the read strobe.

Each channel has the following controls and outputs:
- A power-of-two prescaler on its count clock.
- A choice between free running and wrapping at a programmable interval.
- A stop bit and a restart bit.
- Pending-event flags that clear when they are read.
- A registered, level-high interrupt line.

The registers of one kind for all three channels sit next to each other at a 4-byte stride. A driver can therefore address any channel by adding four times its index to the channel-0 offset.

Top module: `ptmr_top`

## Requirements
- R1: Byte addresses for channel n (n = 0..2): clock control 0x00+4n, counter control 0x0C+4n, count (read-only) 0x18+4n, interval 0x24+4n, status (read-only) 0x54+4n, enable 0x60+4n. Every other word reads as 0. Read data appears in the cycle of the read strobe and is 0 when no read is strobed.
- R2: After reset, counter control reads 0x1 (stopped), clock control reads 0, the interval reads 0xFFFF, and count, status, enable and `irq_o` are all 0.
- R3: While counter control bit 0 is 1, the count holds its value.
- R4: Writing 1 to counter control bit 4 loads 0 into the count and into the prescaler phase at that edge. The bit always reads back as 0.
- R5: In clock control, bit 0 turns the prescaler on and bits [4:1] hold a code N. With the prescaler on, the count advances once every 2^(N+1) clocks. With it off, the count advances every clock.
- R6: With counter control bit 1 set, the count runs 0..interval. On the next count step after reaching the interval it returns to 0 and sets status bit 0.
- R7: With counter control bit 1 clear, the count runs freely. Its step from 0xFFFF to 0 sets status bit 3.
- R8: A status read returns the pending bits and clears them at that edge. A bit set at the same edge stays set.
- R9: `irq_o[n]` is the registered OR of status bits 0 and 3, each masked by the same bit of the enable register. It falls at the edge that ends a status read, unless a new event arrives at that edge.
- R10: Counter control bit 5 is stored and reads back, but it has no effect on counting. Other unused bits read as 0, and writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as the read strobe |
| irq_o | output | 3 | Interrupt line, one per channel |

## Verification
The hardest state to reach is the free-running overflow. The count must travel all 65536 steps before status bit 3 can rise. The stimulus restarts a channel with the prescaler off and idles for an exact, computed number of cycles. It then reads the count as it passes 0xFFFD, 0xFFFE, 0xFFFF and 0 before it reads the overflow flag.

A second awkward case is a status read that coincides with a new event. Setting the interval to 0 raises an event on every clock, so every status read collides with a fresh set.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  // word index (byte address / 4) of each register kind for channel 0
  localparam int unsigned WIX_CLK  = 0;
  localparam int unsigned WIX_CTRL = 3;
  localparam int unsigned WIX_CNT  = 6;
  localparam int unsigned WIX_INTV = 9;
  localparam int unsigned WIX_STAT = 21;
  localparam int unsigned WIX_IEN  = 24;

  // clock control fields
  localparam int unsigned CK_EN   = 0;
  localparam int unsigned CK_CODE = 1;
  // counter control fields
  localparam int unsigned CC_STOP = 0;
  localparam int unsigned CC_MODE = 1;
  localparam int unsigned CC_RST  = 4;
  localparam int unsigned CC_WAVE = 5;
  // status / enable positions
  localparam int unsigned ST_INTV = 0;
  localparam int unsigned ST_OVF  = 3;

  typedef struct packed {
    logic wave;
    logic mode;
    logic stop;
  } ctrl_t;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              run_i,
  input  logic              clr_i,
  output logic              tick_o
);
  localparam int unsigned PRE_W = (1 << CODE_W) + 1;

  logic [PRE_W-2:0] pcnt_q;
  logic [PRE_W-1:0] lim;
  logic             hit;

  assign lim    = (PRE_W'(1) << ({1'b0, code_i} + (CODE_W+1)'(1))) - PRE_W'(1);
  assign hit    = {1'b0, pcnt_q} >= lim;
  assign tick_o = !en_i || hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pcnt_q <= '0;
    else if (clr_i)            pcnt_q <= '0;
    else if (run_i && en_i)    pcnt_q <= hit ? '0 : pcnt_q + 1'b1;
  end

  AST_PRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_i && !clr_i && hit) |=> (pcnt_q == '0)); // R5
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned DW     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_clk_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_intv_i,
  input  logic             wr_ien_i,
  input  logic             rd_stat_i,
  input  logic [CNT_W-1:0] wd_i,
  output logic [DW-1:0]    clk_word_o,
  output logic [DW-1:0]    ctrl_word_o,
  output logic [DW-1:0]    cnt_word_o,
  output logic [DW-1:0]    intv_word_o,
  output logic [DW-1:0]    stat_word_o,
  output logic [DW-1:0]    ien_word_o,
  output logic             irq_o
);
  logic              pre_en_q;
  logic [CODE_W-1:0] code_q;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  intv_q, cnt_q, cnt_d;
  logic [1:0]        stat_q, stat_d, ien_q, ien_d;   // [0]=interval, [1]=overflow
  logic              irq_q;
  logic              tick, run, rst_req, set_intv, set_ovf;

  assign rst_req = wr_ctrl_i && wd_i[CC_RST];
  assign run     = !ctrl_q.stop && tick;

  ptmr_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pre_en_q),
    .code_i(code_q),
    .run_i (!ctrl_q.stop),
    .clr_i (rst_req),
    .tick_o(tick)
  );

  always_comb begin
    cnt_d    = cnt_q;
    set_intv = 1'b0;
    set_ovf  = 1'b0;
    if (rst_req) begin
      cnt_d = '0;
    end else if (run) begin
      if (ctrl_q.mode) begin
        if (cnt_q >= intv_q) begin
          cnt_d    = '0;
          set_intv = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d   = cnt_q + 1'b1;
        set_ovf = &cnt_q;
      end
    end
  end

  // a read clears, a same-edge event survives
  assign stat_d = (rd_stat_i ? 2'b00 : stat_q) | {set_ovf, set_intv};
  assign ien_d  = wr_ien_i ? {wd_i[ST_OVF], wd_i[ST_INTV]} : ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q <= 1'b0;
      code_q   <= '0;
      ctrl_q   <= '{wave: 1'b0, mode: 1'b0, stop: 1'b1};
      intv_q   <= '1;
      cnt_q    <= '0;
      stat_q   <= '0;
      ien_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_clk_i) begin
        pre_en_q <= wd_i[CK_EN];
        code_q   <= wd_i[CK_CODE +: CODE_W];
      end
      if (wr_ctrl_i) ctrl_q <= '{wave: wd_i[CC_WAVE], mode: wd_i[CC_MODE], stop: wd_i[CC_STOP]};
      if (wr_intv_i) intv_q <= wd_i;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      irq_q  <= |(stat_d & ien_d);
    end
  end

  assign irq_o       = irq_q;
  assign clk_word_o  = DW'({code_q, pre_en_q});
  assign ctrl_word_o = DW'({ctrl_q.wave, 3'b000, ctrl_q.mode, ctrl_q.stop});
  assign cnt_word_o  = DW'(cnt_q);
  assign intv_word_o = DW'(intv_q);
  assign stat_word_o = DW'({stat_q[1], 2'b00, stat_q[0]});
  assign ien_word_o  = DW'({ien_q[1], 2'b00, ien_q[0]});

  AST_HOLD_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.stop && !rst_req) |=> (cnt_q == $past(cnt_q))); // R3
  AST_RST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> (cnt_q == '0)); // R4
  AST_INTV_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ctrl_q.mode && !rst_req && cnt_q >= intv_q) |=> (cnt_q == '0 && stat_q[0])); // R6
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !ctrl_q.mode && !rst_req && &cnt_q) |=> stat_q[1]); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !set_intv && !set_ovf) |=> (stat_q == 2'b00)); // R8
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !set_intv && !set_ovf) |=> !irq_o); // R9
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned WI_W = AW - 2;

  logic [WI_W-1:0] widx;
  logic [DW-1:0]   clk_w [NUM_CH];
  logic [DW-1:0]   ctrl_w[NUM_CH];
  logic [DW-1:0]   cnt_w [NUM_CH];
  logic [DW-1:0]   intv_w[NUM_CH];
  logic [DW-1:0]   stat_w[NUM_CH];
  logic [DW-1:0]   ien_w [NUM_CH];
  logic            unused_bits;

  assign widx        = addr_i[AW-1:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:CNT_W]};

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    ptmr_channel #(.CNT_W(CNT_W), .CODE_W(CODE_W), .DW(DW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_clk_i   (wr_en_i && widx == WI_W'(WIX_CLK  + n)),
      .wr_ctrl_i  (wr_en_i && widx == WI_W'(WIX_CTRL + n)),
      .wr_intv_i  (wr_en_i && widx == WI_W'(WIX_INTV + n)),
      .wr_ien_i   (wr_en_i && widx == WI_W'(WIX_IEN  + n)),
      .rd_stat_i  (rd_en_i && widx == WI_W'(WIX_STAT + n)),
      .wd_i       (wdata_i[CNT_W-1:0]),
      .clk_word_o (clk_w[n]),
      .ctrl_word_o(ctrl_w[n]),
      .cnt_word_o (cnt_w[n]),
      .intv_word_o(intv_w[n]),
      .stat_word_o(stat_w[n]),
      .ien_word_o (ien_w[n]),
      .irq_o      (irq_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (widx == WI_W'(WIX_CLK  + n)) rdata_o = clk_w[n];
        if (widx == WI_W'(WIX_CTRL + n)) rdata_o = ctrl_w[n];
        if (widx == WI_W'(WIX_CNT  + n)) rdata_o = cnt_w[n];
        if (widx == WI_W'(WIX_INTV + n)) rdata_o = intv_w[n];
        if (widx == WI_W'(WIX_STAT + n)) rdata_o = stat_w[n];
        if (widx == WI_W'(WIX_IEN  + n)) rdata_o = ien_w[n];
      end
    end
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0)); // R1
endmodule

// File: tb/ptmr_top_bench.sv
module ptmr_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int n_run  = 0;
  int n_fail = 0;

  localparam logic [7:0] A_CLK = 8'h00, A_CTRL = 8'h0C, A_CNT = 8'h18,
                         A_INTV = 8'h24, A_STAT = 8'h54, A_IEN = 8'h60;

  always #4 clk_i = ~clk_i;

  ptmr_top u_ptmr_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] ra(input logic [7:0] base, input int ch);
    return base + 8'(4 * ch);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // every bus op starts at a falling edge and takes exactly one clock
  task automatic op_wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic op_rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    op_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    rd_chk("R2 clk ctrl", ra(A_CLK, 0), 32'h0);
    rd_chk("R2 ctrl", ra(A_CTRL, 1), 32'h1);
    rd_chk("R2 count", ra(A_CNT, 2), 32'h0);
    rd_chk("R2 interval", ra(A_INTV, 0), 32'hFFFF);
    rd_chk("R2 status", ra(A_STAT, 1), 32'h0);
    rd_chk("R2 enable", ra(A_IEN, 2), 32'h0);
    chk("R2 irq", 32'(irq_o), 32'h0);
    rd_chk("R1 unmapped", 8'h30, 32'h0);
    chk("R1 idle rdata", rdata_o, 32'h0);
  endtask

  task automatic t_stride();
    op_wr(ra(A_INTV, 1), 32'h1234);
    rd_chk("R1 ch1 interval", ra(A_INTV, 1), 32'h1234);
    rd_chk("R1 ch2 interval", ra(A_INTV, 2), 32'hFFFF);
    rd_chk("R1 ch0 interval", ra(A_INTV, 0), 32'hFFFF);
  endtask

  task automatic t_ctrl_bits();
    op_wr(ra(A_CTRL, 2), 32'h13);
    rd_chk("R4 reset bit reads 0", ra(A_CTRL, 2), 32'h03);
    op_wr(ra(A_CTRL, 2), 32'hFFFF_FFEF);
    rd_chk("R10 ctrl readback", ra(A_CTRL, 2), 32'h23);
    op_wr(ra(A_CNT, 2), 32'h5555);
    rd_chk("R10 count write ignored", ra(A_CNT, 2), 32'h0);
    op_wr(ra(A_CTRL, 2), 32'h01);
  endtask

  task automatic t_stop_hold();
    repeat (5) @(negedge clk_i);
    rd_chk("R3 stopped count", ra(A_CNT, 0), 32'h0);
  endtask

  task automatic t_interval();
    op_wr(ra(A_IEN, 0), 32'h1);
    op_wr(ra(A_INTV, 0), 32'h4);
    op_wr(ra(A_CTRL, 0), 32'h12);
    for (int j = 0; j < 7; j++) rd_chk("R6 interval count", ra(A_CNT, 0), 32'(j % 5));
    chk("R9 irq raised", 32'(irq_o[0]), 32'h1);
    rd_chk("R6 interval flag", ra(A_STAT, 0), 32'h1);
    chk("R9 irq drops after read", 32'(irq_o[0]), 32'h0);
    op_wr(ra(A_CTRL, 0), 32'h01);
  endtask

  task automatic t_prescale();
    op_wr(ra(A_CLK, 1), 32'h3);      // on, code 1 -> divide by 4
    op_wr(ra(A_CTRL, 1), 32'h10);
    for (int j = 0; j < 10; j++) rd_chk("R5 prescaled count", ra(A_CNT, 1), 32'(j / 4));
    op_wr(ra(A_CTRL, 1), 32'h01);
  endtask

  task automatic t_same_cycle();
    op_wr(ra(A_INTV, 0), 32'h0);
    op_wr(ra(A_CTRL, 0), 32'h12);
    @(negedge clk_i);
    rd_chk("R8 status set", ra(A_STAT, 0), 32'h1);
    rd_chk("R8 set survives read", ra(A_STAT, 0), 32'h1);
    chk("R9 irq held", 32'(irq_o[0]), 32'h1);
    op_wr(ra(A_CTRL, 0), 32'h01);
    rd_chk("R8 last event", ra(A_STAT, 0), 32'h1);
    rd_chk("R8 cleared", ra(A_STAT, 0), 32'h0);
    chk("R9 irq low", 32'(irq_o[0]), 32'h0);
  endtask

  task automatic t_overflow();
    op_wr(ra(A_CTRL, 2), 32'h10);
    repeat (65533) @(negedge clk_i);
    rd_chk("R7 count", ra(A_CNT, 2), 32'hFFFD);
    rd_chk("R7 count", ra(A_CNT, 2), 32'hFFFE);
    rd_chk("R7 count", ra(A_CNT, 2), 32'hFFFF);
    rd_chk("R7 wrapped", ra(A_CNT, 2), 32'h0);
    chk("R9 masked irq", 32'(irq_o[2]), 32'h0);
    rd_chk("R7 overflow flag", ra(A_STAT, 2), 32'h8);
    op_wr(ra(A_CTRL, 2), 32'h01);
    rd_chk("R3 hold", ra(A_CNT, 2), 32'h3);
    rd_chk("R3 hold", ra(A_CNT, 2), 32'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_stride();
    t_ctrl_bits();
    t_stop_hold();
    t_interval();
    t_prescale();
    t_same_cycle();
    t_overflow();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule